// File: doc/BRIEF.md
# Command Stream Register-Write Sequencer

This block reads 32-bit command words from a valid/ready stream. Each header word selects an operation through a 4-bit opcode in bits 31:28. The block turns the header and any payload words after it into single register write transactions. Each transaction carries a target class, a 12-bit register offset and a 32-bit data word.

Five operations produce writes:

- **Class select** switches the current class and may be followed by payload words.
- **Incrementing burst** walks the offset up by one per payload word.
- **Fixed-address burst** keeps one offset for every payload word.
- **Masked scatter** places one payload word per set mask bit.
- **Immediate** writes a 16-bit constant taken from the header itself.

Two further opcodes, restart and gather, are only decoded. Their fields appear as a one-cycle pulse on a side-band event port. The block does not execute them.

Any other opcode is dropped and sets a sticky error flag. The block sits between a command fetch unit and a register bus. The write port back-pressures the command stream: no command word is taken while a write is waiting for acceptance.

Top module: `cmd_write_seq`

## Requirements
- R1: After reset, wr_valid, evt_valid and err_flag are 0, cmd_ready is 1, and the current class is 0.
- R2: Opcode 4 (immediate) emits exactly one write with no payload words. Its offset is header bits 27:16 and its data is header bits 15:0, zero-extended to 32 bits, in the current class.
- R3: Opcode 1 (incrementing) takes the count N from bits 15:0 and the start offset S from bits 27:16. It consumes N payload words and writes word i to offset S+i, wrapping modulo 4096.
- R4: Opcode 2 (fixed-address) takes N payload words and writes all of them to the offset in bits 27:16. The header 0x20000000 (offset 0, count 0) is a no-op: it produces no write, and the next word is taken as a header.
- R5: Opcode 3 (masked scatter) takes a 16-bit mask from bits 15:0. It consumes one payload word per set bit and writes them in ascending bit order to offset bits 27:16 plus the bit index.
- R6: Opcode 0 (class select) sets the current class to header bits 15:6. That class applies to all later writes, including the payload of the same header. Its 6-bit mask in bits 5:0 is applied as in R5, starting from the offset in bits 27:16.
- R7: A count of 0 in opcode 1 or 2, or a mask of 0 in opcode 0 or 3, produces no write, and the next word is taken as a header.
- R8: While wr_valid is 1 and wr_ready is 0, wr_class, wr_offset and wr_data hold steady. While wr_valid is 1, cmd_ready is 0.
- R9: Opcode 5 (restart) emits no write. It pulses evt_valid with evt_gather=0 and evt_addr equal to header bits 27:0 shifted left by 4.
- R10: Opcode 6 (gather) emits no write. It pulses evt_valid with evt_gather=1, and with evt_gather_reg, evt_gather_incr, evt_offset and evt_count taken from header bits 15, 14, 27:16 and 13:0.
- R11: Opcodes 7 to 15 set err_flag, which stays set until reset. The word produces no write and no event, and the next word is taken as a header.
- R12: A write or event appears on the outputs in the cycle right after the edge that accepts the word which causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Command word can be taken |
| cmd_word | input | 32 | Command header or payload word |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Register bus accepts the write |
| wr_class | output | 10 | Target class of the write |
| wr_offset | output | 12 | Register offset of the write |
| wr_data | output | 32 | Write data |
| evt_valid | output | 1 | One-cycle restart/gather event |
| evt_gather | output | 1 | 1 for gather, 0 for restart |
| evt_addr | output | 32 | Restart target byte address |
| evt_gather_reg | output | 1 | Gather targets a register |
| evt_gather_incr | output | 1 | Gather in incrementing mode |
| evt_offset | output | 12 | Gather register offset |
| evt_count | output | 14 | Gather word count |
| err_flag | output | 1 | Sticky undefined-opcode flag |

## Verification
Writes and events are registered, so each appears one cycle after the edge that takes the word causing it. The bench drives every word on a falling edge and holds it until a falling-edge sample shows cmd_ready high. It then checks wr_valid and evt_valid at the very next falling edge.

Writes are gathered at falling edges when wr_valid and wr_ready are both high. Each scenario then idles a few cycles and compares the gathered list in order against expected values, which catches missing, extra and misordered writes. The stall case holds wr_ready low for several cycles and samples the held fields each cycle.

// File: rtl/cmd_write_seq.sv
module cmd_write_seq #(
  parameter int CLASS_W = 10,
  parameter int OFF_W   = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [31:0]        cmd_word,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [CLASS_W-1:0] wr_class,
  output logic [OFF_W-1:0]   wr_offset,
  output logic [DATA_W-1:0]  wr_data,
  output logic               evt_valid,
  output logic               evt_gather,
  output logic [31:0]        evt_addr,
  output logic               evt_gather_reg,
  output logic               evt_gather_incr,
  output logic [OFF_W-1:0]   evt_offset,
  output logic [13:0]        evt_count,
  output logic               err_flag
);
  localparam logic [1:0] M_INC = 2'd0, M_FIX = 2'd1, M_MSK = 2'd2;

  logic               in_pay;
  logic [1:0]         mode;
  logic [OFF_W-1:0]   base;
  logic [15:0]        left;
  logic [15:0]        bits;
  logic [CLASS_W-1:0] cur_class;
  logic [3:0]         low_idx;

  wire        take     = cmd_valid && cmd_ready;
  wire [3:0]  op       = cmd_word[31:28];
  wire [11:0] hdr_off  = cmd_word[27:16];
  wire [15:0] hdr_lo   = cmd_word[15:0];
  wire [15:0] bits_nxt = bits & (bits - 16'd1);

  assign cmd_ready = !wr_valid;

  always_comb begin
    low_idx = 4'd0;
    for (int i = 15; i >= 0; i--)
      if (bits[i]) low_idx = i[3:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pay          <= 1'b0;
      mode            <= M_INC;
      base            <= '0;
      left            <= '0;
      bits            <= '0;
      cur_class       <= '0;
      wr_valid        <= 1'b0;
      wr_class        <= '0;
      wr_offset       <= '0;
      wr_data         <= '0;
      evt_valid       <= 1'b0;
      evt_gather      <= 1'b0;
      evt_addr        <= '0;
      evt_gather_reg  <= 1'b0;
      evt_gather_incr <= 1'b0;
      evt_offset      <= '0;
      evt_count       <= '0;
      err_flag        <= 1'b0;
    end else begin
      evt_valid <= 1'b0;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (take && !in_pay) begin
        case (op)
          4'd0: begin
            cur_class <= cmd_word[15:6];
            base      <= hdr_off;
            bits      <= {10'd0, cmd_word[5:0]};
            mode      <= M_MSK;
            in_pay    <= cmd_word[5:0] != 6'd0;
          end
          4'd1, 4'd2: begin
            base   <= hdr_off;
            left   <= hdr_lo;
            mode   <= (op == 4'd1) ? M_INC : M_FIX;
            in_pay <= hdr_lo != 16'd0;
          end
          4'd3: begin
            base   <= hdr_off;
            bits   <= hdr_lo;
            mode   <= M_MSK;
            in_pay <= hdr_lo != 16'd0;
          end
          4'd4: begin
            wr_valid  <= 1'b1;
            wr_class  <= cur_class;
            wr_offset <= hdr_off;
            wr_data   <= {{(DATA_W-16){1'b0}}, hdr_lo};
          end
          4'd5: begin
            evt_valid       <= 1'b1;
            evt_gather      <= 1'b0;
            evt_addr        <= {cmd_word[27:0], 4'd0};
            evt_gather_reg  <= 1'b0;
            evt_gather_incr <= 1'b0;
            evt_offset      <= '0;
            evt_count       <= '0;
          end
          4'd6: begin
            evt_valid       <= 1'b1;
            evt_gather      <= 1'b1;
            evt_addr        <= '0;
            evt_gather_reg  <= cmd_word[15];
            evt_gather_incr <= cmd_word[14];
            evt_offset      <= hdr_off;
            evt_count       <= cmd_word[13:0];
          end
          default: err_flag <= 1'b1;
        endcase
      end else if (take) begin
        wr_valid <= 1'b1;
        wr_class <= cur_class;
        wr_data  <= cmd_word[DATA_W-1:0];
        case (mode)
          M_INC: begin
            wr_offset <= base;
            base      <= base + 1'b1;
            left      <= left - 16'd1;
            if (left == 16'd1) in_pay <= 1'b0;
          end
          M_FIX: begin
            wr_offset <= base;
            left      <= left - 16'd1;
            if (left == 16'd1) in_pay <= 1'b0;
          end
          default: begin
            wr_offset <= base + {{(OFF_W-4){1'b0}}, low_idx};
            bits      <= bits_nxt;
            if (bits_nxt == 16'd0) in_pay <= 1'b0;
          end
        endcase
      end
    end
  end

  AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !cmd_ready); // R8
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_offset) && $stable(wr_data) && $stable(wr_class))); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R11
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_pay && op >= 4'd7) |=> (err_flag && !evt_valid)); // R11
  AST_WR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(take)); // R12
  AST_EVT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(take)); // R12
endmodule

// File: tb/cmd_write_seq_bench.sv
module cmd_write_seq_bench;
  localparam time PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, wr_ready = 1;
  logic [31:0] cmd_word = 0;
  logic cmd_ready, wr_valid, evt_valid, evt_gather, evt_gather_reg, evt_gather_incr, err_flag;
  logic [9:0] wr_class;
  logic [11:0] wr_offset, evt_offset;
  logic [31:0] wr_data, evt_addr;
  logic [13:0] evt_count;

  int tests = 0, fails = 0, evts = 0;
  bit done = 0;
  logic [53:0] wq[$];

  always #(PERIOD/2) clk = ~clk;

  cmd_write_seq u_cmd_write_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_class(wr_class), .wr_offset(wr_offset), .wr_data(wr_data),
    .evt_valid(evt_valid), .evt_gather(evt_gather), .evt_addr(evt_addr),
    .evt_gather_reg(evt_gather_reg), .evt_gather_incr(evt_gather_incr),
    .evt_offset(evt_offset), .evt_count(evt_count), .err_flag(err_flag));

  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) wq.push_back({wr_class, wr_offset, wr_data});
    if (rst_n && evt_valid) evts++;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [31:0] w);
    cmd_valid = 1; cmd_word = w;
    while (1) begin
      if (cmd_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    cmd_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_wr(string req, logic [9:0] c, logic [11:0] o, logic [31:0] d);
    logic [53:0] got;
    if (wq.size() == 0) begin chk(req, 64'h0, {10'd0, c, o, d}); return; end
    got = wq.pop_front();
    chk(req, {10'd0, got}, {10'd0, c, o, d});
  endtask

  task automatic exp_empty(string req);
    chk({req, " no extra writes"}, wq.size(), 0);
    wq.delete();
  endtask

  task automatic t_reset;
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 evt_valid", evt_valid, 0);
    chk("R1 err_flag", err_flag, 0);
    chk("R1 cmd_ready", cmd_ready, 1);
  endtask

  task automatic t_imm;
    send(32'h4123_BEEF);
    chk("R12 wr_valid after accept", wr_valid, 1);
    idle(3);
    exp_wr("R1 R2 immediate class0", 10'd0, 12'h123, 32'h0000_BEEF);
    exp_empty("R2");
  endtask

  task automatic t_incr;
    send(32'h1010_0003);
    send(32'hA); send(32'hB); send(32'hC);
    send(32'h1FFF_0002);
    send(32'h11); send(32'h22);
    idle(3);
    exp_wr("R3 incr 0", 10'd0, 12'h010, 32'hA);
    exp_wr("R3 incr 1", 10'd0, 12'h011, 32'hB);
    exp_wr("R3 incr 2", 10'd0, 12'h012, 32'hC);
    exp_wr("R3 wrap a", 10'd0, 12'hFFF, 32'h11);
    exp_wr("R3 wrap b", 10'd0, 12'h000, 32'h22);
    exp_empty("R3");
  endtask

  task automatic t_fix;
    send(32'h2020_0002);
    send(32'h5555_0001); send(32'h5555_0002);
    send(32'h2000_0000);
    send(32'h4007_0009);
    idle(3);
    exp_wr("R4 fixed 0", 10'd0, 12'h020, 32'h5555_0001);
    exp_wr("R4 fixed 1", 10'd0, 12'h020, 32'h5555_0002);
    exp_wr("R4 nop then header", 10'd0, 12'h007, 32'h9);
    exp_empty("R4");
  endtask

  task automatic t_mask;
    send(32'h3040_8005);
    send(32'hD0); send(32'hD2); send(32'hDF);
    idle(3);
    exp_wr("R5 mask bit0", 10'd0, 12'h040, 32'hD0);
    exp_wr("R5 mask bit2", 10'd0, 12'h042, 32'hD2);
    exp_wr("R5 mask bit15", 10'd0, 12'h04F, 32'hDF);
    exp_empty("R5");
  endtask

  task automatic t_class;
    send((32'h080 << 16) | (32'h155 << 6) | 32'h21);
    send(32'hC0); send(32'hC5);
    send(32'h4001_0001);
    idle(3);
    exp_wr("R6 class payload bit0", 10'h155, 12'h080, 32'hC0);
    exp_wr("R6 class payload bit5", 10'h155, 12'h085, 32'hC5);
    exp_wr("R6 class applies to imm", 10'h155, 12'h001, 32'h1);
    exp_empty("R6");
  endtask

  task automatic t_zero;
    send(32'h1050_0000);
    send(32'h3060_0000);
    send((32'h0 << 16) | (32'h2AA << 6));
    send(32'h2070_0000);
    send(32'h4002_0002);
    idle(3);
    exp_wr("R7 zero count/mask skip", 10'h2AA, 12'h002, 32'h2);
    exp_empty("R7");
  endtask

  task automatic t_stall;
    logic [11:0] o0;
    wr_ready = 0;
    send(32'h4033_0042);
    o0 = wr_offset;
    cmd_valid = 1; cmd_word = 32'h4034_0043;
    for (int i = 0; i < 3; i++) begin
      chk("R8 held valid", wr_valid, 1);
      chk("R8 cmd_ready low", cmd_ready, 0);
      chk("R8 held offset/data", {wr_offset, wr_data}, {o0, 32'h42});
      @(negedge clk);
    end
    cmd_valid = 0;
    wr_ready = 1;
    idle(3);
    exp_wr("R8 stalled write", 10'h2AA, 12'h033, 32'h42);
    exp_empty("R8");
  endtask

  task automatic t_restart;
    int e0 = evts;
    send(32'h5000_1234);
    chk("R9 evt_valid", evt_valid, 1);
    chk("R9 evt_gather", evt_gather, 0);
    chk("R9 evt_addr", evt_addr, 32'h0001_2340);
    idle(3);
    chk("R9 one event", evts - e0, 1);
    exp_empty("R9");
  endtask

  task automatic t_gather;
    send(32'h6033_C005);
    chk("R10 evt_valid", evt_valid, 1);
    chk("R10 fields", {evt_gather, evt_gather_reg, evt_gather_incr, evt_offset, evt_count},
        {1'b1, 1'b1, 1'b1, 12'h033, 14'd5});
    send(32'h6000_8003);
    chk("R10 nonincr fields", {evt_gather_reg, evt_gather_incr, evt_count}, {1'b1, 1'b0, 14'd3});
    idle(3);
    exp_empty("R10");
  endtask

  task automatic t_err;
    int e0 = evts;
    send(32'h7123_4567);
    chk("R11 err set", err_flag, 1);
    send(32'hF000_0000);
    send(32'h4011_0011);
    idle(3);
    chk("R11 err sticky", err_flag, 1);
    chk("R11 no event", evts - e0, 0);
    exp_wr("R11 next word is header", 10'h2AA, 12'h011, 32'h11);
    exp_empty("R11");
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset(); t_imm(); t_incr(); t_fix(); t_mask(); t_class();
    t_zero(); t_stall(); t_restart(); t_gather(); t_err();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule